// File: doc/BRIEF.md
# Multi-Source Interrupt Routing Controller

This block collects interrupt requests from seven groups of sources and steers each one onto one of three processor request lines: critical, system-management and standard. The groups are four external pins, two tick timers, eight general timer events, nineteen peripheral requests, two real-time-clock events, eight wake-up pins and eight plain GPIO interrupts. The watchdog has no entry here and never raises a routed request.

The groups are not treated alike. Each external pin passes through a two-flop synchroniser and can be set to level or edge detection. Edge detection holds a pending bit until software clears it by writing one. The peripheral requests are reduced to two tier requests, HI and LO, by a per-peripheral tier bit. Peripheral 0, the DMA engine, always belongs to the HI tier. The eight wake-up pins are merged into one source. The result is 27 internal sources. Each source has an enable bit and a 2-bit routing field. A status word gives software the lowest-numbered enabled, pending source for each line.

Software uses a word-addressed synchronous register bus. Writes take effect at the clock edge. Read data appears one cycle after the read request.

Top module: `irq_router`

## Requirements
- R1: After reset, all three request lines are low, rdata_o is 0, and the sense, enable and routing registers read 0. The tier register reads 1.
- R2: Word address map: 0 sense, 1 enable, 2 tier, 3 pending (read; write-one-to-clear), 4 status (read only), 5 and 6 routing. A read request (req_i=1, we_i=0) loads rdata_o at the next clock edge. rdata_o holds its value in any cycle without a read. Unmapped addresses read 0.
- R3: Pending bit numbering: 3..0 are the external pins. Bit 4 is the peripheral HI tier, bit 5 the peripheral LO tier and bit 6 the merged wake-up pins. Bits 8..7 are the tick timers, 16..9 the general timers, 18..17 the real-time-clock events and 26..19 the GPIO pins.
- R4: An external pin with sense bit 0 (level) is pending while its doubly synchronised value is 1. A change at the pin reaches a request line at the third clock edge.
- R5: An external pin with sense bit 1 (edge) becomes pending on a rising edge of its synchronised value and stays pending after the pin falls. Writing 1 to that bit at the pending address clears it. Writing 0 has no effect. A pin change reaches a request line at the fourth edge.
- R6: Tier register bit p set to 1 puts peripheral p in the HI tier, and 0 puts it in the LO tier. Bit 0 (DMA) is HI whatever is written and always reads 1. A tier source is pending while any of its peripherals requests.
- R7: Source 6 is pending while any of the eight wake-up pins is high.
- R8: The routing field of source s is bits 2*(s%16)+1:2*(s%16) of routing word 5+s/16. Code 00 routes to no line, 01 to critical, 10 to system-management and 11 to standard.
- R9: A source with enable bit 0 drives no request line but still reads as pending.
- R10: Each request line is the OR of its enabled, pending, routed sources and is registered. A timer, peripheral, wake-up or GPIO input reaches it at the next clock edge.
- R11: Status byte 0 describes the critical line, byte 1 the system-management line and byte 2 the standard line. In each byte, bits 4:0 hold the lowest enabled pending source routed to that line and bit 7 is set when one exists. Bits 4:0 are 0 when none exists.
- R12: If an edge arrives in the same cycle as a write-one-to-clear of that bit, the bit stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_i | input | 4 | External request pins (asynchronous) |
| tick_i | input | 2 | Tick timer requests |
| gtm_i | input | 8 | General timer requests |
| per_i | input | 19 | Peripheral requests, bit 0 is DMA |
| rtc_i | input | 2 | Real-time-clock requests |
| wake_i | input | 8 | Wake-up pin requests |
| gpio_i | input | 8 | Plain GPIO requests |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 4 | Bus word address |
| wdata_i | input | 32 | Bus write data |
| rdata_o | output | 32 | Bus read data, one cycle after the read |
| crit_o | output | 1 | Critical request line |
| smi_o | output | 1 | System-management request line |
| std_o | output | 1 | Standard request line |

## Verification
The hardest case to reach from the ports is a clear write that lands in the same cycle as a new edge on that pin (R12). The edge passes through three flops before it is recognised, so the clear must be aimed at one particular cycle. The bench raises the pin just after a falling clock edge and waits two rising edges. It then presents the clear so that the third edge sees the detected rise and the write together. A pending read afterwards shows whether the set was kept. Random-looking mixes of all groups are covered by a vector table, with outputs and the status word compared against a model built from the requirements.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  typedef enum logic [1:0] {
    RT_NONE = 2'b00,
    RT_CRIT = 2'b01,
    RT_SMI  = 2'b10,
    RT_STD  = 2'b11
  } route_e;

  localparam int unsigned A_SENSE = 0;
  localparam int unsigned A_MASK  = 1;
  localparam int unsigned A_TIER  = 2;
  localparam int unsigned A_PEND  = 3;
  localparam int unsigned A_STAT  = 4;
  localparam int unsigned A_ROUTE = 5;
  localparam int unsigned N_LINES = 3;
endpackage

// File: rtl/irq_ext_cond.sv
module irq_ext_cond #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edge_mode_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] s1_q, s2_q, prev_q, lat_q, rise;

  assign rise = s2_q & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
      // set beats clear
      lat_q  <= (lat_q & ~clr_i) | (rise & edge_mode_i);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    assign pend_o[i] = edge_mode_i[i] ? lat_q[i] : s2_q[i];

    // R5
    edge_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lat_q[i]) |-> $past(rise[i] && edge_mode_i[i]));
    // R5
    w1c_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && !rise[i]) |=> !lat_q[i]);
    // R12
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[i] && rise[i] && edge_mode_i[i]) |=> lat_q[i]);
  end
endmodule

// File: rtl/irq_per_tier.sv
module irq_per_tier #(
  parameter int unsigned N = 19
) (
  input  logic [N-1:0] per_i,
  input  logic [N-1:0] tier_i,
  output logic         hi_o,
  output logic         lo_o
);
  logic [N-1:0] eff_tier;

  // DMA request pinned to HI tier
  assign eff_tier = tier_i | N'(1);
  assign hi_o     = |(per_i & eff_tier);
  assign lo_o     = |(per_i & ~eff_tier);
endmodule

// File: rtl/irq_lowest.sv
module irq_lowest #(
  parameter int unsigned N  = 27,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        valid_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int unsigned N_EXT  = 4,
  parameter int unsigned N_TICK = 2,
  parameter int unsigned N_GTM  = 8,
  parameter int unsigned N_PER  = 19,
  parameter int unsigned N_RTC  = 2,
  parameter int unsigned N_WAKE = 8,
  parameter int unsigned N_GPIO = 8,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_EXT-1:0]  ext_i,
  input  logic [N_TICK-1:0] tick_i,
  input  logic [N_GTM-1:0]  gtm_i,
  input  logic [N_PER-1:0]  per_i,
  input  logic [N_RTC-1:0]  rtc_i,
  input  logic [N_WAKE-1:0] wake_i,
  input  logic [N_GPIO-1:0] gpio_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              crit_o,
  output logic              smi_o,
  output logic              std_o
);
  localparam int unsigned IDX_HI = N_EXT;
  localparam int unsigned IDX_LO = N_EXT + 1;
  localparam int unsigned IDX_WK = N_EXT + 2;
  localparam int unsigned N_DIR  = N_TICK + N_GTM + N_RTC + N_GPIO;
  localparam int unsigned N_SRC  = N_EXT + 3 + N_DIR;
  localparam int unsigned IDX_W  = $clog2(N_SRC);
  localparam int unsigned RT_PER = DATA_W / 2;
  localparam int unsigned N_RW   = (N_SRC + RT_PER - 1) / RT_PER;

  logic [N_EXT-1:0]   sense_q;
  logic [N_SRC-1:0]   mask_q;
  logic [N_PER-1:0]   tier_q;
  logic [2*N_SRC-1:0] route_q;
  logic [DATA_W-1:0]  rdata_q, rd_val, stat;
  logic [N_LINES-1:0] out_q, line_vld;
  logic [N_LINES-1:0][IDX_W-1:0] line_idx;
  logic [N_LINES-1:0][N_SRC-1:0] hit;
  logic [N_EXT-1:0]   ext_pend, ext_clr;
  logic               hi_req, lo_req;
  logic [N_SRC-1:0]   pend;
  logic               wr, rd;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;
  assign ext_clr = (wr && addr_i == ADDR_W'(A_PEND)) ? wdata_i[N_EXT-1:0] : '0;

  irq_ext_cond #(.N(N_EXT)) i_ext (
    .clk_i, .rst_ni, .pin_i(ext_i), .edge_mode_i(sense_q),
    .clr_i(ext_clr), .pend_o(ext_pend)
  );

  irq_per_tier #(.N(N_PER)) i_tier (
    .per_i, .tier_i(tier_q), .hi_o(hi_req), .lo_o(lo_req)
  );

  assign pend = {gpio_i, rtc_i, gtm_i, tick_i, |wake_i, lo_req, hi_req, ext_pend};

  for (genvar l = 0; l < N_LINES; l++) begin : g_line
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign hit[l][s] = pend[s] && mask_q[s] && (route_q[2*s +: 2] == 2'(l + 1));
    end
    irq_lowest #(.N(N_SRC)) i_low (
      .vec_i(hit[l]), .valid_o(line_vld[l]), .idx_o(line_idx[l])
    );
    assign stat[8*l +: 8] = {line_vld[l], {(7-IDX_W){1'b0}}, line_idx[l]};

    // R11
    stat_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_vld[l] |-> (hit[l][line_idx[l]] && (hit[l] & ((N_SRC'(1) << line_idx[l]) - 1'b1)) == '0));
    // R11
    stat_none_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_vld[l] |-> (hit[l] == '0 && line_idx[l] == '0));
  end
  assign stat[DATA_W-1:8*N_LINES] = '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q <= '0;
      mask_q  <= '0;
      tier_q  <= '0;
      route_q <= '0;
      out_q   <= '0;
      rdata_q <= '0;
    end else begin
      for (int l = 0; l < N_LINES; l++) out_q[l] <= |hit[l];
      if (rd) rdata_q <= rd_val;
      if (wr) begin
        if (addr_i == ADDR_W'(A_SENSE)) sense_q <= wdata_i[N_EXT-1:0];
        if (addr_i == ADDR_W'(A_MASK))  mask_q  <= wdata_i[N_SRC-1:0];
        if (addr_i == ADDR_W'(A_TIER))  tier_q  <= wdata_i[N_PER-1:0];
        for (int s = 0; s < N_SRC; s++) begin
          if (addr_i == ADDR_W'(A_ROUTE + s / RT_PER))
            route_q[2*s +: 2] <= wdata_i[2*(s % RT_PER) +: 2];
        end
      end
    end
  end

  always_comb begin
    rd_val = '0;
    case (int'(addr_i))
      A_SENSE: rd_val[N_EXT-1:0] = sense_q;
      A_MASK:  rd_val[N_SRC-1:0] = mask_q;
      A_TIER:  rd_val[N_PER-1:0] = tier_q | N_PER'(1);
      A_PEND:  rd_val[N_SRC-1:0] = pend;
      A_STAT:  rd_val = stat;
      default: begin
        for (int s = 0; s < N_SRC; s++) begin
          if (int'(addr_i) == A_ROUTE + s / RT_PER)
            rd_val[2*(s % RT_PER) +: 2] = route_q[2*s +: 2];
        end
      end
    endcase
  end

  assign rdata_o = rdata_q;
  assign crit_o  = out_q[0];
  assign smi_o   = out_q[1];
  assign std_o   = out_q[2];

  // R9
  mask_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_q == '0) |=> !(crit_o || smi_o || std_o));
  // R2
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd |=> $stable(rdata_o));
  // R6
  dma_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_i[0] |-> pend[IDX_HI]);
  // R7
  wake_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[IDX_WK] == (wake_i != '0));
  // R6
  lo_tier_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend[IDX_LO] |-> (per_i[N_PER-1:1] != '0));
endmodule

// File: tb/test_irq_router.sv
module test_irq_router;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 27;

  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0]  ext_i = '0;
  logic [1:0]  tick_i = '0, rtc_i = '0;
  logic [7:0]  gtm_i = '0, wake_i = '0, gpio_i = '0;
  logic [18:0] per_i = '0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic        crit_o, smi_o, std_o;

  int checks = 0, fails = 0;
  logic [1:0]    rt [NS];
  logic [NS-1:0] mask_v;
  logic [31:0]   rv;

  irq_router i_irq_router (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // {ext, per, wake, dir(tick,gtm,rtc,gpio), exp {std,smi,crit}}
  localparam logic [53:0] VEC [9] = '{
    {4'b0000, 19'h00000, 8'h00, 20'h00000, 3'b000},
    {4'b0001, 19'h00000, 8'h00, 20'h00000, 3'b001},
    {4'b0000, 19'h00001, 8'h00, 20'h00000, 3'b001},
    {4'b0000, 19'h00004, 8'h00, 20'h00000, 3'b100},
    {4'b0000, 19'h00000, 8'h80, 20'h00000, 3'b010},
    {4'b0000, 19'h00000, 8'h00, 20'h80000, 3'b100},
    {4'b1010, 19'h40000, 8'h01, 20'h00001, 3'b110},
    {4'b1111, 19'h7FFFF, 8'hFF, 20'hFFFFF, 3'b111},
    {4'b0000, 19'h00002, 8'h00, 20'h00000, 3'b001}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(int a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = 4'(a); wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic bus_read(int a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 4'(a);
    @(negedge clk_i);
    req_i = 1'b0;
    d = rdata_o;
  endtask

  function automatic logic [31:0] route_word(int w);
    logic [31:0] r = '0;
    for (int s = 16*w; s < NS && s < 16*w + 16; s++) r[2*(s-16*w) +: 2] = rt[s];
    return r;
  endfunction

  // level-mode pending model, tier bit1 HI plus forced DMA
  function automatic logic [NS-1:0] model_pend(logic [3:0] e, logic [18:0] p,
                                               logic [7:0] w, logic [19:0] d);
    return {d, |w, |p[18:2], |p[1:0], e};
  endfunction

  function automatic logic [31:0] model_stat(logic [NS-1:0] p);
    logic [31:0] r = '0;
    for (int l = 0; l < 3; l++) begin
      for (int s = NS - 1; s >= 0; s--) begin
        if (p[s] && mask_v[s] && rt[s] == 2'(l + 1)) r[8*l +: 8] = 8'h80 | 8'(s);
      end
    end
    return r;
  endfunction

  initial begin
    repeat (20000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    check("R1 lines", {29'b0, std_o, smi_o, crit_o}, 0);
    check("R1 rdata", rdata_o, 0);
    bus_read(1, rv); check("R1 mask", rv, 0);
    bus_read(2, rv); check("R1 tier", rv, 1);
    bus_read(5, rv); check("R1 route", rv, 0);
    bus_read(0, rv); check("R1 sense", rv, 0);

    // configuration
    foreach (rt[s]) rt[s] = 2'b11;
    rt[0] = 2'b01; rt[1] = 2'b10; rt[4] = 2'b01; rt[6] = 2'b10;
    mask_v = '1;
    bus_write(1, 32'(mask_v));
    bus_write(5, route_word(0));
    bus_write(6, route_word(1));
    bus_write(2, 32'h0000_0002);
    bus_read(5, rv); check("R8 route word 0", rv, route_word(0));
    bus_read(6, rv); check("R8 route word 1", rv, route_word(1));
    bus_read(2, rv); check("R6 tier dma forced", rv, 32'h3);
    bus_read(4, rv); check("R11 idle status", rv, 0);
    bus_read(15, rv); check("R2 unmapped", rv, 0);

    // vector table: R3 R4 R6 R7 R8 R10 R11
    foreach (VEC[k]) begin
      @(negedge clk_i);
      {ext_i, per_i, wake_i, tick_i, gtm_i, rtc_i, gpio_i} = VEC[k][53:3];
      repeat (4) @(negedge clk_i);
      check("R8 lines", {29'b0, std_o, smi_o, crit_o}, 32'(VEC[k][2:0]));
      bus_read(3, rv);
      check("R3 pending", rv, 32'(model_pend(ext_i, per_i, wake_i,
                                             {gpio_i, rtc_i, gtm_i, tick_i})));
      bus_read(4, rv);
      check("R11 status", rv, model_stat(model_pend(ext_i, per_i, wake_i,
                                                    {gpio_i, rtc_i, gtm_i, tick_i})));
    end
    @(negedge clk_i);
    {ext_i, per_i, wake_i, tick_i, gtm_i, rtc_i, gpio_i} = '0;
    repeat (4) @(negedge clk_i);

    // R9 disabled source still pending
    bus_write(1, 32'(mask_v) & ~32'h1);
    ext_i[0] = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R9 masked line", {31'b0, crit_o}, 0);
    bus_read(3, rv); check("R9 pending visible", rv & 32'h1, 32'h1);
    ext_i[0] = 1'b0;
    bus_write(1, 32'(mask_v));
    repeat (4) @(negedge clk_i);

    // R4 level latency: third edge
    ext_i[2] = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R4 before third edge", {31'b0, std_o}, 0);
    @(negedge clk_i);
    check("R4 at third edge", {31'b0, std_o}, 1);
    ext_i[2] = 1'b0;
    repeat (4) @(negedge clk_i);

    // R10 direct latency: next edge
    tick_i[0] = 1'b1;
    @(negedge clk_i);
    check("R10 tick next edge", {31'b0, std_o}, 1);
    tick_i[0] = 1'b0;
    @(negedge clk_i);
    check("R10 tick drop", {31'b0, std_o}, 0);

    // R5 edge mode
    bus_write(0, 32'h8);
    ext_i[3] = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R5 before fourth edge", {31'b0, std_o}, 0);
    @(negedge clk_i);
    check("R5 at fourth edge", {31'b0, std_o}, 1);
    ext_i[3] = 1'b0;
    repeat (5) @(negedge clk_i);
    check("R5 held after pin low", {31'b0, std_o}, 1);
    bus_write(3, 32'h0);
    repeat (2) @(negedge clk_i);
    check("R5 zero write ignored", {31'b0, std_o}, 1);
    bus_write(3, 32'h8);
    @(negedge clk_i);
    check("R5 cleared line", {31'b0, std_o}, 0);
    bus_read(3, rv); check("R5 cleared pending", rv & 32'h8, 0);

    // R12 edge and clear in the same cycle
    ext_i[3] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    bus_write(3, 32'h8);
    bus_read(3, rv); check("R12 set wins", rv & 32'h8, 32'h8);
    ext_i[3] = 1'b0;
    bus_write(3, 32'h8);
    bus_read(3, rv); check("R12 later clear", rv & 32'h8, 0);

    // R8 code 00 routes nowhere
    rt[7] = 2'b00;
    bus_write(5, route_word(0));
    tick_i[0] = 1'b1;
    repeat (2) @(negedge clk_i);
    check("R8 unrouted", {29'b0, std_o, smi_o, crit_o}, 0);
    bus_read(4, rv); check("R11 unrouted status", rv, 0);
    tick_i[0] = 1'b0;

    // R2 hold without read
    bus_read(2, rv);
    repeat (3) @(negedge clk_i);
    check("R2 rdata hold", rdata_o, 32'h3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule